// File: doc/BRIEF.md
# Frame sync guard

This block keeps frame timing for a demodulated optical-disc channel bitstream. One clock cycle is one channel bit. A free-running counter of 588 bits predicts where the next frame sync should fall. Sync pulses from an upstream pattern detector are accepted only inside a small window centred on that predicted point. An accepted pulse realigns the counter. When no pulse arrives before the window closes, the block emits a generated sync from its own counter.

The block counts consecutive generated syncs. When that count reaches a selectable limit, it declares loss of sync and drops the window. It then locks onto the next detected pulse wherever it falls. A status flag shows whether the latest frame came from a real sync. A slow, debounced lock indication is derived from that flag, sampled once every sixteen frames.

Top module: `frame_sync_guard`

## Requirements
- R1: The frame counter period is 588 clock cycles. With no sync input, the block emits one frame strobe every 588 cycles.
- R2: `win_wide`=0 selects a 3-bit window: predicted point ±1 cycle. `win_wide`=1 selects a 7-bit window: predicted point ±3 cycles.
- R3: A sync pulse accepted at clock edge E gives `frame_strobe` high for the cycle after E. The next predicted point is then 588 edges after E.
- R4: While in sync, a pulse outside the window is ignored. No strobe is given, the counter is not moved and the status flag keeps its value.
- R5: If no pulse is accepted by the last edge of the window (predicted point + half width), a generated strobe follows that edge.
- R6: `lim_sel` sets how many generated syncs in a row raise `resync_pend`: 00 gives 2, 01 gives 4, 10 gives 8 and 11 gives 13. The flag rises with the strobe of the last of them.
- R7: While `resync_pend` is high, any sync pulse is accepted at once. It clears `resync_pend` and realigns the counter.
- R8: `sync_locked` goes high with the strobe of an accepted sync and low with the strobe of a generated sync.
- R9: Only one pulse is accepted per window. A second pulse in the same window is ignored.
- R10: During and right after reset, `frame_strobe`, `sync_locked` and `lock_out` are low and `resync_pend` is high. The generated-sync count is cleared.
- R11: `lock_out` samples `sync_locked` on every 16th frame strobe, counted from reset. A high sample sets `lock_out` on the next cycle.
- R12: `lock_out` falls only on the 8th consecutive low sample. Fewer low samples leave it high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel bit clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_det | input | 1 | Raw sync-pattern detect pulse |
| win_wide | input | 1 | Window select: 0 gives ±1 bit, 1 gives ±3 bits |
| lim_sel | input | 2 | Code for the generated-sync limit before unlock |
| frame_strobe | output | 1 | One-cycle frame sync, real or generated |
| sync_locked | output | 1 | High when the last frame came from a real sync |
| resync_pend | output | 1 | Unlock flag; window is disabled while high |
| lock_out | output | 1 | Debounced lock indication |

## Verification
The assertions assume `sync_det` is sampled on `clk` and that a pulse lasts one cycle. They also assume `win_wide` and `lim_sel` do not change in the middle of a window. The stimulus therefore drives every sync as a single-cycle pulse on the falling edge. It changes the control inputs only right after an accepted sync, far from the next window. Pulse positions are placed at exact offsets from the last accepted sync, so that each window edge is hit or just missed.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

  // Frame length in channel bits and window half-widths.
  localparam int unsigned FRAME_BITS   = 588;
  localparam int unsigned HALF_NARROW  = 1;
  localparam int unsigned HALF_WIDE    = 3;

  // Generated-sync limits, indexed by the select code.
  localparam int unsigned LIMIT_C0 = 2;
  localparam int unsigned LIMIT_C1 = 4;
  localparam int unsigned LIMIT_C2 = 8;
  localparam int unsigned LIMIT_C3 = 13;

  // Lock filter: frames per sample, low samples needed to drop.
  localparam int unsigned SAMPLE_EVERY = 16;
  localparam int unsigned DROP_AFTER   = 8;

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/fsg_frame_ctr.sv
module fsg_frame_ctr #(
  parameter int unsigned FRAME_LEN   = fsg_pkg::FRAME_BITS,
  parameter int unsigned NARROW_HALF = fsg_pkg::HALF_NARROW,
  parameter int unsigned WIDE_HALF   = fsg_pkg::HALF_WIDE,
  localparam int unsigned CW         = $clog2(FRAME_LEN)
) (
  input  logic clk,
  input  logic rst,
  input  logic realign,
  input  logic win_wide,
  output logic in_win_o,
  output logic at_close_o,
  output logic after_win_o
);

  localparam logic [CW-1:0] LAST = CW'(FRAME_LEN - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] half_w;
  logic [CW-1:0] lo_edge;

  // Half-width of the window picked at run time.
  assign half_w  = win_wide ? CW'(WIDE_HALF) : CW'(NARROW_HALF);
  assign lo_edge = CW'(FRAME_LEN) - half_w;

  // Predicted sync sits at count 0; window wraps around it.
  assign in_win_o    = (cnt_q >= lo_edge) || (cnt_q <= half_w);
  assign at_close_o  = (cnt_q == half_w);
  assign after_win_o = (cnt_q == half_w + CW'(1));

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (realign)      cnt_q <= CW'(1);
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + CW'(1);
  end

  // R1: counter wraps after the last count of the frame
  a_r1_wrap: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == LAST && !realign) |=> (cnt_q == '0));

  // R3: realignment restarts the frame one count past the sync
  a_r3_restart: assert property (@(posedge clk) disable iff (rst)
    realign |=> (in_win_o && !after_win_o));

endmodule

// File: rtl/fsg_guard.sv
module fsg_guard #(
  parameter int unsigned LIM0 = fsg_pkg::LIMIT_C0,
  parameter int unsigned LIM1 = fsg_pkg::LIMIT_C1,
  parameter int unsigned LIM2 = fsg_pkg::LIMIT_C2,
  parameter int unsigned LIM3 = fsg_pkg::LIMIT_C3,
  localparam int unsigned LIM_MAX = fsg_pkg::max4(LIM0, LIM1, LIM2, LIM3),
  localparam int unsigned IW      = $clog2(LIM_MAX + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sync_det,
  input  logic       in_win,
  input  logic       at_close,
  input  logic       after_win,
  input  logic [1:0] lim_sel,
  output logic       realign,
  output logic       strobe_o,
  output logic       locked_o,
  output logic       unlocked_o
);

  logic [IW-1:0] limit;
  logic [IW-1:0] ins_q;
  logic          got_q;
  logic          unlocked_q;
  logic          strobe_q;
  logic          locked_q;
  logic          accept;
  logic          insert;

  always_comb begin
    unique case (lim_sel)
      2'b00:   limit = IW'(LIM0);
      2'b01:   limit = IW'(LIM1);
      2'b10:   limit = IW'(LIM2);
      default: limit = IW'(LIM3);
    endcase
  end

  // Decide what happens this channel bit.
  assign accept  = sync_det && !got_q && (unlocked_q || in_win);
  assign insert  = at_close && !got_q && !accept;
  assign realign = accept;

  always_ff @(posedge clk) begin
    if (rst) begin
      ins_q      <= '0;
      got_q      <= 1'b0;
      unlocked_q <= 1'b1;
      strobe_q   <= 1'b0;
      locked_q   <= 1'b0;
    end else begin
      strobe_q <= accept || insert;
      if (accept) begin
        ins_q      <= '0;
        got_q      <= 1'b1;
        unlocked_q <= 1'b0;
        locked_q   <= 1'b1;
      end else begin
        if (after_win) got_q <= 1'b0;
        if (insert) begin
          locked_q <= 1'b0;
          if (ins_q < limit) ins_q <= ins_q + IW'(1);
          if (ins_q >= limit - IW'(1)) unlocked_q <= 1'b1;
        end
      end
    end
  end

  assign strobe_o   = strobe_q;
  assign locked_o   = locked_q;
  assign unlocked_o = unlocked_q;

  // R7: while unlocked any pulse is taken and clears the flag
  a_r7_reacquire: assert property (@(posedge clk) disable iff (rst)
    (unlocked_q && sync_det) |=> (!unlocked_q && strobe_q && locked_q));

  // R4: outside the window a pulse produces no strobe while in sync
  a_r4_ignore_outside: assert property (@(posedge clk) disable iff (rst)
    (!unlocked_q && sync_det && !in_win) |=> !strobe_q);

  // R9: a second pulse in an already served window yields nothing
  a_r9_one_per_window: assert property (@(posedge clk) disable iff (rst)
    (got_q && sync_det) |=> !strobe_q);

  // R5: a strobe not caused by a pulse is a generated one, status low
  a_r5_generated_low: assert property (@(posedge clk) disable iff (rst)
    (strobe_q && !$past(sync_det)) |-> !locked_q);

  // R8: the status flag only rises together with a strobe
  a_r8_rise_with_strobe: assert property (@(posedge clk) disable iff (rst)
    $rose(locked_q) |-> strobe_q);

  // R6: generated-sync count never passes the largest limit
  a_r6_count_bounded: assert property (@(posedge clk) disable iff (rst)
    ins_q <= IW'(LIM_MAX));

endmodule

// File: rtl/fsg_lock_filter.sv
module fsg_lock_filter #(
  parameter int unsigned LOCK_DIV  = fsg_pkg::SAMPLE_EVERY,
  parameter int unsigned LOCK_DROP = fsg_pkg::DROP_AFTER,
  localparam int unsigned DW       = $clog2(LOCK_DIV),
  localparam int unsigned RW       = $clog2(LOCK_DROP + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  input  logic status,
  output logic lock_o
);

  logic [DW-1:0] div_q;
  logic [RW-1:0] run_q;
  logic          lock_q;
  logic          sample;

  assign sample = strobe && (div_q == DW'(LOCK_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= '0;
      run_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      if (strobe) div_q <= (div_q == DW'(LOCK_DIV - 1)) ? '0 : div_q + DW'(1);
      if (sample) begin
        if (status) begin
          run_q  <= '0;
          lock_q <= 1'b1;
        end else begin
          if (run_q != RW'(LOCK_DROP)) run_q <= run_q + RW'(1);
          if (run_q >= RW'(LOCK_DROP - 1)) lock_q <= 1'b0;
        end
      end
    end
  end

  assign lock_o = lock_q;

  // R11: a high sample sets the output
  a_r11_rise: assert property (@(posedge clk) disable iff (rst)
    (sample && status) |=> lock_q);

  // R12: without a low sample the output cannot fall
  a_r12_hold: assert property (@(posedge clk) disable iff (rst)
    (lock_q && !(sample && !status)) |=> lock_q);

endmodule

// File: rtl/frame_sync_guard.sv
module frame_sync_guard #(
  parameter int unsigned FRAME_LEN   = fsg_pkg::FRAME_BITS,
  parameter int unsigned NARROW_HALF = fsg_pkg::HALF_NARROW,
  parameter int unsigned WIDE_HALF   = fsg_pkg::HALF_WIDE,
  parameter int unsigned LIM0        = fsg_pkg::LIMIT_C0,
  parameter int unsigned LIM1        = fsg_pkg::LIMIT_C1,
  parameter int unsigned LIM2        = fsg_pkg::LIMIT_C2,
  parameter int unsigned LIM3        = fsg_pkg::LIMIT_C3,
  parameter int unsigned LOCK_DIV    = fsg_pkg::SAMPLE_EVERY,
  parameter int unsigned LOCK_DROP   = fsg_pkg::DROP_AFTER
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sync_det,
  input  logic       win_wide,
  input  logic [1:0] lim_sel,
  output logic       frame_strobe,
  output logic       sync_locked,
  output logic       resync_pend,
  output logic       lock_out
);

  logic realign;
  logic in_win;
  logic at_close;
  logic after_win;

  fsg_frame_ctr #(
    .FRAME_LEN  (FRAME_LEN),
    .NARROW_HALF(NARROW_HALF),
    .WIDE_HALF  (WIDE_HALF)
  ) ctr_i (
    .clk        (clk),
    .rst        (rst),
    .realign    (realign),
    .win_wide   (win_wide),
    .in_win_o   (in_win),
    .at_close_o (at_close),
    .after_win_o(after_win)
  );

  fsg_guard #(
    .LIM0(LIM0), .LIM1(LIM1), .LIM2(LIM2), .LIM3(LIM3)
  ) guard_i (
    .clk       (clk),
    .rst       (rst),
    .sync_det  (sync_det),
    .in_win    (in_win),
    .at_close  (at_close),
    .after_win (after_win),
    .lim_sel   (lim_sel),
    .realign   (realign),
    .strobe_o  (frame_strobe),
    .locked_o  (sync_locked),
    .unlocked_o(resync_pend)
  );

  fsg_lock_filter #(
    .LOCK_DIV (LOCK_DIV),
    .LOCK_DROP(LOCK_DROP)
  ) filt_i (
    .clk   (clk),
    .rst   (rst),
    .strobe(frame_strobe),
    .status(sync_locked),
    .lock_o(lock_out)
  );

endmodule

// File: tb/frame_sync_guard_tb.sv
`timescale 1ns/1ps
module frame_sync_guard_tb_top;

  localparam int FL = 588;

  logic       clk = 1'b0;
  logic       rst;
  logic       sync_det;
  logic       win_wide;
  logic [1:0] lim_sel;
  logic       frame_strobe, sync_locked, resync_pend, lock_out;

  int vectors = 0;
  int fails   = 0;
  int t       = 0;
  bit done    = 0;

  always #5 clk = ~clk;

  frame_sync_guard dut_i (
    .clk(clk), .rst(rst), .sync_det(sync_det), .win_wide(win_wide),
    .lim_sel(lim_sel), .frame_strobe(frame_strobe), .sync_locked(sync_locked),
    .resync_pend(resync_pend), .lock_out(lock_out)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b (t=%0d)", tag, act, exp, t);
    end
  endtask

  task automatic step();
    @(negedge clk);
    t++;
  endtask

  task automatic goto(input int e);
    while (t < e) step();
  endtask

  task automatic pulse();
    sync_det = 1'b1;
    step();
    sync_det = 1'b0;
  endtask

  task automatic sync_at(input int e);
    goto(e - 1);
    pulse();
  endtask

  // Lock filter model built from R11/R12, fed by observed outputs.
  int  scount = 0;
  int  lowrun = 0;
  logic exp_lock = 1'b0;
  int  lock_prints = 0;
  bit  sampled_prev = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (sampled_prev) vectors++;
      if (lock_out !== exp_lock) begin
        fails++;
        if (lock_prints < 10)
          $display("FAIL R11/R12 lock_out: actual %b expected %b", lock_out, exp_lock);
        lock_prints++;
      end
      sampled_prev = 0;
      if (frame_strobe) begin
        scount++;
        if (scount % 16 == 0) begin
          sampled_prev = 1;
          if (sync_locked) begin exp_lock = 1'b1; lowrun = 0; end
          else begin
            lowrun++;
            if (lowrun >= 8) exp_lock = 1'b0;
          end
        end
      end
    end
  end

  task automatic t_reset();
    chk("R10 strobe", frame_strobe, 1'b0);
    chk("R10 sync_locked", sync_locked, 1'b0);
    chk("R10 resync_pend", resync_pend, 1'b1);
    chk("R10 lock_out", lock_out, 1'b0);
  endtask

  task automatic t_acquire();
    repeat (100) step();
    pulse();
    chk("R7 acquire strobe", frame_strobe, 1'b1);
    chk("R7 acquire clears resync", resync_pend, 1'b0);
    chk("R8 locked after accept", sync_locked, 1'b1);
    t = 0;
  endtask

  task automatic t_track_narrow();
    goto(FL - 1);
    chk("R3 no strobe before predicted", frame_strobe, 1'b0);
    pulse();
    chk("R3 on-time accept", frame_strobe, 1'b1);
    t = 0;
    sync_at(FL - 1);
    chk("R2 narrow early by 1", frame_strobe, 1'b1);
    t = 0;
    sync_at(FL + 1);
    chk("R2 narrow late by 1", frame_strobe, 1'b1);
    chk("R8 locked late", sync_locked, 1'b1);
    t = 0;
  endtask

  task automatic t_reject_insert();
    sync_at(FL - 2);
    chk("R4 early by 2 ignored", frame_strobe, 1'b0);
    chk("R4 status kept", sync_locked, 1'b1);
    goto(FL);
    chk("R5 no strobe at predicted", frame_strobe, 1'b0);
    step();
    chk("R5 generated strobe", frame_strobe, 1'b1);
    chk("R8 low after generated", sync_locked, 1'b0);
    chk("R6 one insert no unlock", resync_pend, 1'b0);
    sync_at(2 * FL);
    chk("R4 counter not moved", frame_strobe, 1'b1);
    chk("R8 relocked", sync_locked, 1'b1);
    t = 0;
  endtask

  task automatic t_wide();
    win_wide = 1'b1;
    sync_at(FL - 3);
    chk("R2 wide early by 3", frame_strobe, 1'b1);
    t = 0;
    sync_at(FL - 4);
    chk("R2 wide early by 4 ignored", frame_strobe, 1'b0);
    sync_at(FL + 3);
    chk("R2 wide late by 3", frame_strobe, 1'b1);
    chk("R2 wide late locked", sync_locked, 1'b1);
    t = 0;
    goto(FL + 3);
    chk("R5 wide generated at close", frame_strobe, 1'b1);
    sync_at(FL + 4);
    chk("R4 wide late by 4 ignored", frame_strobe, 1'b0);
    sync_at(2 * FL);
    chk("R3 wide back on time", frame_strobe, 1'b1);
    t = 0;
    win_wide = 1'b0;
  endtask

  task automatic t_duplicate();
    sync_at(1);
    chk("R9 duplicate ignored", frame_strobe, 1'b0);
    sync_at(FL - 1);
    chk("R9 counter not realigned", frame_strobe, 1'b1);
    t = 0;
  endtask

  task automatic t_limit(input logic [1:0] code, input int lim);
    lim_sel = code;
    for (int k = 1; k <= lim; k++) begin
      goto(k * FL);
      chk("R1 no strobe at predicted", frame_strobe, 1'b0);
      step();
      chk("R1 generated every frame", frame_strobe, 1'b1);
      chk("R6 unlock at limit", resync_pend, (k == lim));
    end
    sync_at(lim * FL + 300);
    chk("R7 off-window accepted", frame_strobe, 1'b1);
    chk("R7 resync cleared", resync_pend, 1'b0);
    t = 0;
    sync_at(FL);
    chk("R7 realigned to new sync", frame_strobe, 1'b1);
    t = 0;
    lim_sel = 2'b11;
  endtask

  task automatic t_lock_filter();
    for (int i = 0; i < 20; i++) begin
      sync_at(FL);
      t = 0;
    end
    step();
    chk("R11 lock_out high", lock_out, 1'b1);
    goto(145 * FL + 10);
    chk("R12 lock_out dropped", lock_out, 1'b0);
  endtask

  initial begin
    rst = 1'b1; sync_det = 1'b0; win_wide = 1'b0; lim_sel = 2'b11;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_acquire();
    t_track_narrow();
    t_reject_insert();
    t_wide();
    t_duplicate();
    t_limit(2'b00, 2);
    t_limit(2'b01, 4);
    t_limit(2'b10, 8);
    t_limit(2'b11, 13);
    t_lock_filter();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule